// File: doc/BRIEF.md
# Redundant Clock Monitor and Switch

This block watches two reference clocks from a faster, free-running sampling clock. Each reference is brought into the sampling domain and its edges are detected. A per-input counter measures how long the input has gone without an edge. If an input stays at one level for longer than a set number of sampling cycles, a sticky alarm flag is raised for that input. The second input is watched in the same way whether or not it is selected.

A small selection machine decides which input is the active reference. If the active input fails and the other input is healthy, the machine switches to the other input. It then keeps that choice, even after the failed clock comes back. A failure on the inactive input only raises its flag. A one-cycle alarm-clear pulse clears both flags and returns the selection to the preferred input. A manual override ties the selection to the preferred-input pin.

Top module: `clkmon_top`

## Requirements
- R1: Both inputs are monitored at all times and independently. A stall on the input that is not selected raises that input's flag, and the other flag stays clear.
- R2: A failure is declared only when the synchronized input shows no edge for more than `STALL_LIMIT` sampling cycles. An input that toggles at least once every `STALL_LIMIT` cycles never raises a flag. A stalled input's flag is set no later than `STALL_LIMIT`+6 cycles after its last transition, and not within 8 cycles of it.
- R3: Once set, a flag (`bad_flag[0]` for `ref_clk[0]`, `bad_flag[1]` for `ref_clk[1]`) stays HIGH when its input recovers, until an alarm clear or a reset.
- R4: If the selected input fails while the other input's flag is clear and is not being set in the same cycle, and override is low, `sel_out` moves to the other input. If the other flag is set, the selection does not change.
- R5: A failure on the input that is not selected does not change `sel_out`.
- R6: A one-cycle HIGH on `alarm_clr` clears both flags on the next edge. It also loads `sel_out` from `pri_sel`. An input that is still stalled has its flag set again one cycle later.
- R7: While `man_ovr` is HIGH, `sel_out` follows `pri_sel` with one cycle of latency and no automatic switch occurs. The flags keep updating.
- R8: After an automatic switch, the selection is kept after the failed input recovers.
- R9: A synchronous `rst` clears both flags and the stall counters, and loads `sel_out` from `pri_sel`. Encoding: `sel_out` is 0 for `ref_clk[0]` and 1 for `ref_clk[1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_smp | input | 1 | Free-running sampling clock |
| rst | input | 1 | Synchronous reset, active HIGH |
| ref_clk | input | 2 | The two monitored reference clocks |
| pri_sel | input | 1 | Preferred input (0 or 1) |
| man_ovr | input | 1 | Manual override: selection follows `pri_sel` |
| alarm_clr | input | 1 | One-cycle pulse that clears both flags |
| bad_flag | output | 2 | Sticky per-input failure flags |
| sel_out | output | 1 | Index of the active reference |

## Verification
A stall counter that reloads wrongly would show up as a flag raised while the input is still toggling. A counter that never saturates past the limit would show up as a flag that never rises within about twenty cycles of a stall. A wrong selection state shows on `sel_out` within one cycle of the triggering event:
- a switch on a failure of the inactive input,
- a switch toward a flagged input,
- a bounce back to the first input once it recovers,
- override not being obeyed.

A flag that is not sticky drops on the cycles after the failed input restarts.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  typedef enum logic {SEL_IN0 = 1'b0, SEL_IN1 = 1'b1} sel_t;
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync (
  input  logic clk_smp,
  input  logic rst,
  input  logic async_in,
  output logic edge_seen
);
  logic s1, s2, s3;

  always_ff @(posedge clk_smp) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign edge_seen = s2 ^ s3;
endmodule

// File: rtl/clkmon_stall.sv
module clkmon_stall #(
  parameter int STALL_LIMIT = 12
) (
  input  logic clk_smp,
  input  logic rst,
  input  logic edge_seen,
  output logic stalled
);
  localparam int SAT   = STALL_LIMIT + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c, input logic e);
    if (e)                          return '0;
    else if (c == CNT_W'(SAT))      return c;
    else                            return c + 1'b1;
  endfunction

  function automatic logic over_limit(input logic [CNT_W-1:0] c);
    return c > CNT_W'(STALL_LIMIT);
  endfunction

  always_ff @(posedge clk_smp) begin
    if (rst) cnt <= '0;
    else     cnt <= next_count(cnt, edge_seen);
  end

  assign stalled = over_limit(cnt);

  AST_NO_STALL_AFTER_EDGE: assert property (@(posedge clk_smp) disable iff (rst)
    edge_seen |=> !stalled); // R2
endmodule

// File: rtl/clkmon_select.sv
module clkmon_select
  import clkmon_pkg::*;
(
  input  logic       clk_smp,
  input  logic       rst,
  input  logic       pri_sel,
  input  logic       man_ovr,
  input  logic       alarm_clr,
  input  logic [1:0] set_evt,
  input  logic [1:0] bad_q,
  output logic       sel
);
  sel_t cur;
  logic cur_b, oth_b, cur_fails, oth_ok, auto_sw;

  assign cur_b     = (cur == SEL_IN1);
  assign oth_b     = ~cur_b;
  assign cur_fails = set_evt[cur_b];
  assign oth_ok    = !bad_q[oth_b] && !set_evt[oth_b];
  assign auto_sw   = cur_fails && oth_ok;

  always_ff @(posedge clk_smp) begin
    if (rst || man_ovr || alarm_clr) cur <= sel_t'(pri_sel);
    else if (auto_sw)                cur <= sel_t'(oth_b);
  end

  assign sel = cur_b;

  AST_SEC_FAIL_HOLDS: assert property (@(posedge clk_smp) disable iff (rst)
    (!man_ovr && !alarm_clr && set_evt[oth_b] && !set_evt[cur_b]) |=> $stable(sel)); // R5
  AST_OVR_FOLLOWS: assert property (@(posedge clk_smp) disable iff (rst)
    man_ovr |=> (sel == $past(pri_sel))); // R7
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top #(
  parameter int STALL_LIMIT = 12
) (
  input  logic       clk_smp,
  input  logic       rst,
  input  logic [1:0] ref_clk,
  input  logic       pri_sel,
  input  logic       man_ovr,
  input  logic       alarm_clr,
  output logic [1:0] bad_flag,
  output logic       sel_out
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] edge_seen, stalled, set_evt, bad_q;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_ch
    clkmon_sync u_sync (
      .clk_smp  (clk_smp),
      .rst      (rst),
      .async_in (ref_clk[g]),
      .edge_seen(edge_seen[g])
    );
    clkmon_stall #(.STALL_LIMIT(STALL_LIMIT)) u_stall (
      .clk_smp  (clk_smp),
      .rst      (rst),
      .edge_seen(edge_seen[g]),
      .stalled  (stalled[g])
    );

    assign set_evt[g] = stalled[g] && !bad_q[g] && !alarm_clr;

    always_ff @(posedge clk_smp) begin
      if (rst || alarm_clr) bad_q[g] <= 1'b0;
      else if (stalled[g])  bad_q[g] <= 1'b1;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk_smp) disable iff (rst)
      (bad_q[g] && !alarm_clr) |=> bad_q[g]); // R3
  end

  clkmon_select u_sel (
    .clk_smp  (clk_smp),
    .rst      (rst),
    .pri_sel  (pri_sel),
    .man_ovr  (man_ovr),
    .alarm_clr(alarm_clr),
    .set_evt  (set_evt),
    .bad_q    (bad_q),
    .sel      (sel_out)
  );

  assign bad_flag = bad_q;

  AST_CLR_EMPTIES: assert property (@(posedge clk_smp) disable iff (rst)
    alarm_clr |=> (bad_q == '0)); // R6
  AST_AUTO_TO_GOOD: assert property (@(posedge clk_smp) disable iff (rst)
    (!man_ovr && !alarm_clr) |=> ((sel_out == $past(sel_out)) || !bad_q[sel_out])); // R4
endmodule

// File: tb/test_clkmon_top.sv
module test_clkmon_top;
  logic       clk_smp = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ref_clk = 2'b00;
  logic       pri_sel = 1'b0;
  logic       man_ovr = 1'b0;
  logic       alarm_clr = 1'b0;
  logic [1:0] bad_flag;
  logic       sel_out;

  logic [1:0] run = 2'b11;
  logic [1:0] ph = 2'd0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [1:0] exp_bad;
    logic       exp_sel;
  } item_t;
  item_t sbq[$];

  clkmon_top #(.STALL_LIMIT(12)) i_clkmon_top (
    .clk_smp(clk_smp), .rst(rst), .ref_clk(ref_clk), .pri_sel(pri_sel),
    .man_ovr(man_ovr), .alarm_clr(alarm_clr), .bad_flag(bad_flag), .sel_out(sel_out)
  );

  always #5 clk_smp = ~clk_smp;

  // reference clocks: each running input toggles every 4 sampling cycles
  always @(posedge clk_smp) begin
    ph <= ph + 2'd1;
    if (ph == 2'd0) begin
      for (int i = 0; i < 2; i++) if (run[i]) ref_clk[i] <= ~ref_clk[i];
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_smp);
  endtask

  task automatic expect_now(input string tag, input logic [1:0] b, input logic s);
    item_t it;
    it.tag = tag; it.exp_bad = b; it.exp_sel = s;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic stop_at(input int i, input logic lvl);
    @(negedge clk_smp);
    while (ref_clk[i] != lvl) @(negedge clk_smp);
    run[i] = 1'b0;
  endtask

  task automatic pulse_clr();
    alarm_clr = 1'b1;
    cyc(1);
    alarm_clr = 1'b0;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (sbq.size() > 0);
      begin
        item_t it;
        it = sbq.pop_front();
        total++;
        if (bad_flag !== it.exp_bad || sel_out !== it.exp_sel) begin
          bad++;
          $display("FAIL %s: bad_flag=%b sel_out=%b expected bad_flag=%b sel_out=%b",
                   it.tag, bad_flag, sel_out, it.exp_bad, it.exp_sel);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(4);
    expect_now("R9 reset state", 2'b00, 1'b0);
    rst = 1'b0;
    cyc(40);
    expect_now("R2 toggling inputs raise no flag", 2'b00, 1'b0);

    // secondary (input 1) stuck HIGH
    stop_at(1, 1'b1);
    cyc(8);
    expect_now("R2 no flag within 8 cycles of stall", 2'b00, 1'b0);
    cyc(12);
    expect_now("R1 R5 unselected input flagged, selection kept", 2'b10, 1'b0);
    run[1] = 1'b1;
    cyc(30);
    expect_now("R3 flag stays after recovery", 2'b10, 1'b0);
    pulse_clr();
    cyc(30);
    expect_now("R6 alarm clear empties flags", 2'b00, 1'b0);

    // primary (input 0) stuck LOW
    stop_at(0, 1'b0);
    cyc(24);
    expect_now("R4 primary failure switches to input 1", 2'b01, 1'b1);
    run[0] = 1'b1;
    cyc(30);
    expect_now("R8 no bounce back after recovery", 2'b01, 1'b1);
    pulse_clr();
    cyc(10);
    expect_now("R6 alarm clear reloads selection", 2'b00, 1'b0);

    // both fail: no switch toward a flagged input
    stop_at(1, 1'b0);
    cyc(24);
    expect_now("R5 secondary stall keeps selection", 2'b10, 1'b0);
    stop_at(0, 1'b1);
    cyc(24);
    expect_now("R4 no switch to flagged input", 2'b11, 1'b0);
    alarm_clr = 1'b1;
    cyc(1);
    alarm_clr = 1'b0;
    expect_now("R6 flags cleared right after pulse", 2'b00, 1'b0);
    cyc(1);
    expect_now("R6 still-stalled inputs flagged again", 2'b11, 1'b0);

    // manual override
    run = 2'b11;
    cyc(30);
    pulse_clr();
    cyc(10);
    man_ovr = 1'b1;
    pri_sel = 1'b1;
    cyc(1);
    expect_now("R7 override follows pri_sel", 2'b00, 1'b1);
    stop_at(1, 1'b1);
    cyc(24);
    expect_now("R7 selected input fails under override, no switch", 2'b10, 1'b1);
    pri_sel = 1'b0;
    cyc(1);
    expect_now("R7 override follows pri_sel change", 2'b10, 1'b0);
    man_ovr = 1'b0;

    // reset loads selection from pri_sel
    pri_sel = 1'b1;
    rst = 1'b1;
    cyc(3);
    expect_now("R9 reset loads pri_sel and clears flags", 2'b00, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule